// File: doc/BRIEF.md
# Multidrop Slave Driver Gate

This block sits between a UART and the line transceiver of one slave node on a shared serial bus, either RS-485 or an RS-232 link whose transmitter can be tristated. The node has to stay off the bus until a master calls it. The block watches every byte the receiver delivers and looks for the node's configured ASCII name. While it waits, the transceiver direction output is held in receive mode, and the local host cannot start a transmission.

When the full name arrives in order, the block switches the transceiver to transmit. It waits one bit time so that the line settles, then asks the UART transmitter to send a single acknowledgment byte. After that the host may send bytes, one frame at a time. The exchange ends when the host pulses its release input or when the master sends the end-of-exchange byte. The block then keeps the driver on until the last frame's stop bit has left the transmitter, turns the driver off and goes back to searching for its name.

The controller has five states. LISTEN is silent name search. LEAD means the driver is on and the block is waiting one bit time. ACK issues the acknowledgment request. EXCHANGE is the host data phase. DRAIN waits for the last frame to finish before the driver turns off. The transitions are:
- LISTEN→LEAD on a name hit.
- LEAD→ACK when the bit-time wait expires.
- ACK→EXCHANGE always, after one cycle.
- EXCHANGE→DRAIN on release or the end byte.
- DRAIN→LISTEN once the frame timer is idle.

The UART is assumed to start the start bit in the cycle of a transmit request. Frames are sent least significant bit first after a start bit and are FRAME_BITS bit times long.

Top module: `mdg_slave_gate`

## Requirements
- R1: After reset, drv_en, tx_req, host_tx_ready and tx_err are all low, and the node is listening.
- R2: drv_en is high (transmit mode) in every state except listening, and low (receive mode) while listening. Bus traffic that is not a complete name never raises it.
- R3: Byte i of the name is name_chars[8*i+7:8*i], with byte 0 expected first. name_len (1 to NAME_MAX; 0 is treated as 1 and larger values as NAME_MAX) gives the number of bytes. drv_en rises in the cycle after the rx_valid cycle carrying the last name byte, and not earlier.
- R4: A byte that breaks a partial match restarts the search. That same byte is checked again as a possible first name byte, so "NNODE" matches the name "NODE".
- R5: The acknowledgment request (tx_req with tx_data = ACK_CHAR) comes exactly CLKS_PER_BIT cycles after the first cycle with drv_en high.
- R6: host_tx_ready is high only in the exchange phase and only once FRAME_CLKS = FRAME_BITS*CLKS_PER_BIT cycles have passed since the previous tx_req. A host request in a ready cycle produces tx_req in the same cycle, with tx_data equal to host_tx_data.
- R7: In the exchange phase, host_release or an rx byte equal to END_CHAR ends the exchange. A host request accepted in the same cycle is still sent. drv_en stays high until the last frame is complete: it falls in the cycle FRAME_CLKS+1 after the last tx_req, or one cycle after the end if no frame is pending.
- R8: A host request while listening produces a one-cycle tx_err pulse and no tx_req.
- R9: In the exchange phase, rx bytes other than END_CHAR have no effect. A host request in a cycle where host_tx_ready is low (outside listening) is dropped, with no tx_req and no tx_err.
- R10: On returning to listening, any partial match from before is discarded and the search starts from name byte 0. A one-byte name matches on a single byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe from the UART receiver |
| rx_data | input | 8 | Received byte |
| name_chars | input | 8*NAME_MAX | Node name, byte 0 in the low bits |
| name_len | input | LEN_W | Number of name bytes |
| host_tx_valid | input | 1 | Host asks to send a byte |
| host_tx_data | input | 8 | Host byte to send |
| host_release | input | 1 | Host ends the exchange |
| host_tx_ready | output | 1 | A host byte would be accepted this cycle |
| tx_req | output | 1 | Transmit request to the UART transmitter |
| tx_data | output | 8 | Byte to transmit with tx_req |
| drv_en | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| tx_err | output | 1 | Host request blocked while silent |

## Verification
A wrong match index shows up at drv_en. It rises either too early, in the cycle after a partial name, or not at all after a full name such as "NNODE", and the per-cycle comparison catches either within one cycle of the offending byte. A wrong frame timer shows up as host_tx_ready or the acknowledgment request in the wrong cycle. It also shows up as drv_en falling before FRAME_CLKS+1 cycles after the last request, and both errors are visible in the very cycle they happen. A state stuck outside listening shows up as a missing tx_err pulse or a driver that never releases the bus.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

    typedef enum logic [2:0] {
        ST_LISTEN   = 3'd0,
        ST_LEAD     = 3'd1,
        ST_ACK      = 3'd2,
        ST_EXCHANGE = 3'd3,
        ST_DRAIN    = 3'd4
    } gate_state_t;

    localparam logic [7:0] DEFAULT_ACK = 8'h06;
    localparam logic [7:0] DEFAULT_END = 8'h04;

endpackage

// File: rtl/mdg_name_matcher.sv
// Sequential name search with restart-and-recheck on mismatch.
module mdg_name_matcher #(
    parameter int NAME_MAX = 8,
    parameter int LEN_W    = $clog2(NAME_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    input  logic [NAME_MAX*8-1:0] name_chars,
    input  logic [LEN_W-1:0]      name_len,
    output logic                  hit
);
    localparam int IDX_W = (NAME_MAX > 1) ? $clog2(NAME_MAX) : 1;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;
    logic [IDX_W-1:0] last_idx;
    logic [7:0]       expect_ch;
    logic [7:0]       first_ch;

    always_comb begin
        if (name_len == '0) begin
            last_idx = '0;
        end else if (int'(name_len) > NAME_MAX) begin
            last_idx = IDX_W'(NAME_MAX - 1);
        end else begin
            last_idx = IDX_W'(int'(name_len) - 1);
        end
    end

    assign expect_ch = name_chars[int'(idx_q)*8 +: 8];
    assign first_ch  = name_chars[7:0];

    always_comb begin
        hit   = 1'b0;
        idx_d = idx_q;
        if (restart) begin
            idx_d = '0;
        end else if (rx_valid) begin
            if (rx_byte == expect_ch) begin
                if (idx_q == last_idx) begin
                    hit   = 1'b1;
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end else if ((rx_byte == first_ch) && (last_idx != '0)) begin
                idx_d = IDX_W'(1);
            end else begin
                idx_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

endmodule

// File: rtl/mdg_frame_timer.sv
// Loadable down counter; idle when it reaches zero.
module mdg_frame_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0);

endmodule

// File: rtl/mdg_slave_gate.sv
module mdg_slave_gate
    import mdg_pkg::*;
#(
    parameter int         NAME_MAX     = 8,
    parameter int         CLKS_PER_BIT = 16,
    parameter int         FRAME_BITS   = 10,
    parameter logic [7:0] ACK_CHAR     = DEFAULT_ACK,
    parameter logic [7:0] END_CHAR     = DEFAULT_END,
    localparam int        LEN_W        = $clog2(NAME_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic [NAME_MAX*8-1:0] name_chars,
    input  logic [LEN_W-1:0]      name_len,
    input  logic                  host_tx_valid,
    input  logic [7:0]            host_tx_data,
    input  logic                  host_release,
    output logic                  host_tx_ready,
    output logic                  tx_req,
    output logic [7:0]            tx_data,
    output logic                  drv_en,
    output logic                  tx_err
);
    localparam int FRAME_CLKS = FRAME_BITS * CLKS_PER_BIT;
    localparam int CNT_W      = $clog2(FRAME_CLKS + 1);
    localparam logic [CNT_W-1:0] LEAD_LOAD  = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] FRAME_LOAD = CNT_W'(FRAME_CLKS - 1);

    gate_state_t      state_q;
    gate_state_t      state_d;
    logic             name_hit;
    logic             timer_idle;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             in_listen;
    logic             host_accept;
    logic             end_seen;

    assign in_listen   = (state_q == ST_LISTEN);
    assign host_accept = (state_q == ST_EXCHANGE) && timer_idle && host_tx_valid;
    assign end_seen    = rx_valid && (rx_data == END_CHAR);

    mdg_name_matcher #(
        .NAME_MAX (NAME_MAX),
        .LEN_W    (LEN_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (!in_listen),
        .rx_valid   (rx_valid && in_listen),
        .rx_byte    (rx_data),
        .name_chars (name_chars),
        .name_len   (name_len),
        .hit        (name_hit)
    );

    mdg_frame_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .idle     (timer_idle)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LISTEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer control
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_LISTEN: begin
                if (name_hit) begin
                    state_d    = ST_LEAD;
                    timer_load = 1'b1;
                    timer_val  = LEAD_LOAD;
                end
            end
            ST_LEAD: begin
                if (timer_idle) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                state_d    = ST_EXCHANGE;
                timer_load = 1'b1;
                timer_val  = FRAME_LOAD;
            end
            ST_EXCHANGE: begin
                if (host_accept) begin
                    timer_load = 1'b1;
                    timer_val  = FRAME_LOAD;
                end
                if (host_release || end_seen) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (timer_idle) begin
                    state_d = ST_LISTEN;
                end
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    // Outputs
    always_comb begin
        drv_en        = 1'b1;
        tx_req        = 1'b0;
        tx_data       = 8'h00;
        host_tx_ready = 1'b0;
        tx_err        = 1'b0;
        unique case (state_q)
            ST_LISTEN: begin
                drv_en = 1'b0;
                tx_err = host_tx_valid;
            end
            ST_LEAD: begin
            end
            ST_ACK: begin
                tx_req  = 1'b1;
                tx_data = ACK_CHAR;
            end
            ST_EXCHANGE: begin
                host_tx_ready = timer_idle;
                tx_req        = host_accept;
                tx_data       = host_tx_data;
            end
            ST_DRAIN: begin
            end
            default: drv_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/mdg_slave_gate_chk.sv
module mdg_slave_gate_chk #(
    parameter int         CLKS_PER_BIT = 16,
    parameter int         FRAME_BITS   = 10,
    parameter logic [7:0] ACK_CHAR     = 8'h06
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_req,
    input logic [7:0] tx_data,
    input logic       drv_en,
    input logic       tx_err,
    input logic       host_tx_ready
);
    localparam int FRAME_CLKS = FRAME_BITS * CLKS_PER_BIT;
    localparam int SAT        = FRAME_CLKS + CLKS_PER_BIT + 2;

    int since_req;
    int on_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_req <= SAT;
            on_cnt    <= 0;
        end else begin
            if (tx_req) since_req <= 1;
            else if (since_req < SAT) since_req <= since_req + 1;
            if (!drv_en) on_cnt <= 0;
            else if (on_cnt < SAT) on_cnt <= on_cnt + 1;
        end
    end

    // R2: a request is only issued with the driver in transmit mode
    a_r2_req_needs_driver: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> drv_en);

    // R5: every request comes at least one bit time after the driver turned on
    a_r5_lead_time: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> on_cnt >= CLKS_PER_BIT);

    // R5: the first request after the driver turns on carries the acknowledgment
    a_r5_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && on_cnt == CLKS_PER_BIT) |-> tx_data == ACK_CHAR);

    // R6: requests are at least one frame apart
    a_r6_frame_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> since_req >= FRAME_CLKS);

    // R6: the host is never offered a slot while the driver is off
    a_r6_ready_driven: assert property (@(posedge clk) disable iff (!rst_n)
        host_tx_ready |-> drv_en);

    // R7: driver release waits for the last frame to leave
    a_r7_hold_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> since_req > FRAME_CLKS);

    // R8: the blocked-request pulse only occurs while silent
    a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> (!drv_en && !tx_req));

endmodule

bind mdg_slave_gate mdg_slave_gate_chk #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .FRAME_BITS   (FRAME_BITS),
    .ACK_CHAR     (ACK_CHAR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_req        (tx_req),
    .tx_data       (tx_data),
    .drv_en        (drv_en),
    .tx_err        (tx_err),
    .host_tx_ready (host_tx_ready)
);

// File: tb/tb_mdg_slave_gate.sv
module tb_mdg_slave_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NMAX  = 8;
    localparam int BIT   = 4;
    localparam int FBITS = 10;
    localparam int FRM   = BIT * FBITS;
    localparam logic [7:0] ACKC = 8'h06;
    localparam logic [7:0] ENDC = 8'h04;
    localparam int LW = $clog2(NMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [NMAX*8-1:0] name_chars = '0;
    logic [LW-1:0] name_len = LW'(4);
    logic host_tx_valid = 1'b0;
    logic [7:0] host_tx_data = 8'h00;
    logic host_release = 1'b0;
    logic host_tx_ready, tx_req, drv_en, tx_err;
    logic [7:0] tx_data;

    mdg_slave_gate #(
        .NAME_MAX(NMAX), .CLKS_PER_BIT(BIT), .FRAME_BITS(FBITS),
        .ACK_CHAR(ACKC), .END_CHAR(ENDC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .name_chars(name_chars), .name_len(name_len),
        .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data),
        .host_release(host_release), .host_tx_ready(host_tx_ready),
        .tx_req(tx_req), .tx_data(tx_data), .drv_en(drv_en), .tx_err(tx_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mode = 0;   // 0 silent,1 lead,2 ack,3 exchange,4 drain
    int m_pos  = 0;
    int m_wait = 0;
    int m_busy = 0;

    function automatic int eff_len();
        if (name_len == 0) return 1;
        if (int'(name_len) > NMAX) return NMAX;
        return int'(name_len);
    endfunction

    function automatic logic [7:0] nm(input int i);
        return name_chars[i*8 +: 8];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_pos = 0; m_wait = 0; m_busy = 0;
        end else begin
            case (m_mode)
                0: if (rx_valid) begin
                    if (rx_data == nm(m_pos)) begin
                        if (m_pos + 1 == eff_len()) begin
                            m_mode = 1; m_pos = 0; m_wait = BIT;
                        end else m_pos++;
                    end else m_pos = (rx_data == nm(0) && eff_len() > 1) ? 1 : 0;
                end
                1: begin
                    m_wait--;
                    if (m_wait == 0) m_mode = 2;
                end
                2: begin m_busy = FRM - 1; m_mode = 3; end
                3: begin
                    if (m_busy == 0 && host_tx_valid) m_busy = FRM - 1;
                    else if (m_busy > 0) m_busy--;
                    if (host_release || (rx_valid && rx_data == ENDC)) m_mode = 4;
                end
                default: begin
                    if (m_busy == 0) m_mode = 0; else m_busy--;
                end
            endcase
        end
    end

    // ---------------- per-cycle comparison and event log ----------------
    int cyc = 0;
    int rise_cyc = -1, ack_cyc = -1, fall_cyc = -1, last_req = -1, prev_req = -1;
    int n_req = 0, n_err = 0;
    logic prev_drv = 1'b0;

    always @(negedge clk) begin
        bit e_drv, e_rdy, e_req, e_err;
        logic [7:0] e_dat;
        cyc++;
        if (rst_n) begin
            e_drv = (m_mode != 0);
            e_rdy = (m_mode == 3) && (m_busy == 0);
            e_req = (m_mode == 2) || (e_rdy && host_tx_valid);
            e_dat = (m_mode == 2) ? ACKC : host_tx_data;
            e_err = (m_mode == 0) && host_tx_valid;
            check(drv_en == e_drv, "R2 drv_en", drv_en, e_drv);
            check(host_tx_ready == e_rdy, "R6 host_tx_ready", host_tx_ready, e_rdy);
            check(tx_req == e_req, "R6 tx_req", tx_req, e_req);
            check(tx_err == e_err, "R8 tx_err", tx_err, e_err);
            if (e_req) check(tx_data == e_dat, "R5 tx_data", tx_data, e_dat);
            if (drv_en && !prev_drv) rise_cyc = cyc;
            if (!drv_en && prev_drv) fall_cyc = cyc;
            if (tx_req) begin
                if (tx_data == ACKC && ack_cyc < rise_cyc) ack_cyc = cyc;
                prev_req = last_req; last_req = cyc; n_req++;
            end
            if (tx_err) n_err++;
            prev_drv = drv_en;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic host_send(input logic [7:0] d);
        @(negedge clk);
        while (!host_tx_ready) @(negedge clk);
        host_tx_valid = 1'b1; host_tx_data = d;
        @(negedge clk); host_tx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        name_chars[7:0] = "N"; name_chars[15:8] = "O";
        name_chars[23:16] = "D"; name_chars[31:24] = "E";
        idle(2);
        check(!drv_en && !tx_req && !host_tx_ready && !tx_err, "R1 reset outputs", drv_en, 0);
        rst_n = 1'b1;
        idle(2);
        check(!drv_en && !host_tx_ready, "R1 after reset", drv_en, 0);

        // R8: request while silent
        @(negedge clk); host_tx_valid = 1'b1; host_tx_data = 8'h55;
        @(negedge clk); host_tx_valid = 1'b0;
        check(n_err == 1, "R8 error pulse count", n_err, 1);
        check(n_req == 0, "R8 no request", n_req, 0);

        // R3: partial name, then a breaking byte
        send_rx("N"); send_rx("O"); send_rx("D");
        check(drv_en == 1'b0, "R3 partial name keeps driver off", drv_en, 0);
        send_rx("X");
        send_rx("E");
        check(drv_en == 1'b0, "R3 stale tail does not match", drv_en, 0);

        // R4: "NNODE" matches through recheck
        send_rx("N"); send_rx("N"); send_rx("O"); send_rx("D");
        check(drv_en == 1'b0, "R4 before last byte", drv_en, 0);
        send_rx("E");
        check(drv_en == 1'b1, "R4 match after recheck", drv_en, 1);
        idle(2 * BIT + 2);
        check(ack_cyc - rise_cyc == BIT, "R5 ack lead time", ack_cyc - rise_cyc, BIT);

        // R9: traffic during exchange and an early host request
        send_rx("Z"); send_rx("N");
        @(negedge clk); host_tx_valid = 1'b1; host_tx_data = 8'h11;
        @(negedge clk); host_tx_valid = 1'b0;
        check(n_req == 1 && n_err == 1, "R9 early request dropped", n_req, 1);
        check(drv_en == 1'b1, "R9 driver still on", drv_en, 1);

        // R6: two host bytes, back to back
        host_send(8'hA5);
        host_send(8'h3C);
        check(last_req - prev_req == FRM, "R6 frame spacing", last_req - prev_req, FRM);

        // R7: end byte while the last frame is in flight
        send_rx(ENDC);
        idle(FRM + 4);
        check(fall_cyc - last_req == FRM + 1, "R7 driver hold", fall_cyc - last_req, FRM + 1);
        check(drv_en == 1'b0, "R7 silent again", drv_en, 0);

        // R10: no carried partial match, then a one-byte name with host release
        send_rx("E");
        check(drv_en == 1'b0, "R10 no carried match", drv_en, 0);
        name_chars[7:0] = "Q"; name_len = LW'(1);
        send_rx("Q");
        check(drv_en == 1'b1, "R10 single-byte name", drv_en, 1);
        idle(FRM + BIT + 4);
        @(negedge clk); host_release = 1'b1;
        @(negedge clk); host_release = 1'b0;
        @(negedge clk);
        check(drv_en == 1'b0, "R7 release with idle timer", drv_en, 0);
        idle(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule